// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block judges whether a twisted-pair Ethernet link is alive and keeps the far end convinced that this side is alive. On the receive side it takes decoded events from the analog front end: a strobe for each valid idle link pulse and a strobe for each data packet. A millisecond timebase strobe measures the silence between them. If the line stays silent for a whole link-loss window, the link is failed. A failed link recovers on a run of consecutive valid link pulses or on any data packet. While the link is good, the block pulls an active-low status output low, which can light an LED, and enables the transmit and receive paths. While the link is failed, it gates both paths off.

A strap input, held low, bypasses the receive-side judgement. The link is then treated as good and both paths stay enabled, whatever arrives on the line. Independently of the strap and of the link state, a generator emits a one-cycle idle link pulse request every idle period while transmit is quiet. The idle timer is held at zero while a packet is being sent, so the first pulse comes one full period after the end of the packet.

An active-low reset, which also serves as power-down, returns all state to its initial values. Every output is then inactive, and the link starts in the failed state.

Top module: `lnk_integrity_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no line events, `link_ok_n` is 1, `tx_en` and `rx_en` are 0, and `nlp_out` is 0. The link starts failed.
- R2: In the failed state with the check enabled (`chk_strap`=1), the link passes in the cycle after the PASS_PULSES-th consecutive `rx_lp` strobe. Passing means `link_ok_n`=0 and `tx_en`=`rx_en`=1. With no `rx_lp` or `rx_pkt`, a failed link stays failed.
- R3: In the failed state with the check enabled, a single `rx_pkt` strobe makes the link pass in the next cycle.
- R4: In the passing state with the check enabled, the link fails in the cycle after the LOSS_MS-th `ms_tick` that is counted without any `rx_lp` or `rx_pkt`. It never fails in a cycle that follows one without `ms_tick`.
- R5: Any `rx_lp` or `rx_pkt` restarts the link-loss window. When such an event falls in the same cycle as the tick that would end the window, the event wins and the link stays passing.
- R6: Link pulses count as consecutive only within the link-loss window. If LOSS_MS ticks pass in the failed state with no `rx_lp`, the partial pulse count is discarded.
- R7: With `chk_strap`=0, in the following cycle `link_ok_n`=0 and `tx_en`=`rx_en`=1, regardless of line events or ticks. When the strap returns high, the link starts passing with a fresh link-loss window.
- R8: While `tx_busy`=0, `nlp_out` is high for exactly one cycle, in the cycle after every NLP_MS-th `ms_tick`. This does not depend on `chk_strap` or on the link state.
- R9: While `tx_busy`=1, the idle timer is held at zero and `nlp_out` stays 0, even on a tick that would have completed a period. The first pulse after `tx_busy` falls comes after NLP_MS further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset / power-down |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| rx_lp | input | 1 | One-cycle strobe per valid received idle link pulse |
| rx_pkt | input | 1 | One-cycle strobe per received data packet |
| tx_busy | input | 1 | High while a packet is being transmitted |
| chk_strap | input | 1 | Low bypasses the receive link check |
| link_ok_n | output | 1 | Low while the link is judged good |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| nlp_out | output | 1 | One-cycle request to emit an idle link pulse |

## Verification
Two cases can land in the same cycle, and both are provoked on purpose. In the first, a received link pulse arrives on exactly the tick that would close the link-loss window. The bench drives the window to its last count and then asserts `rx_lp` and `ms_tick` together. It judges the result by two things: the link must still pass in the next cycle, and a full fresh window must then be needed before it fails. In the second, transmit goes busy on the tick that would complete an idle period. The bench requires `nlp_out` to stay low on that tick and the period to restart from zero once `tx_busy` falls.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic {
        LNK_FAIL = 1'b0,
        LNK_PASS = 1'b1
    } lnk_state_e;

endpackage

// File: rtl/lnk_nlp_gen.sv
module lnk_nlp_gen #(
    parameter int NLP_MS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic tx_busy,
    output logic nlp_pulse
);
    localparam int NW = (NLP_MS > 2) ? $clog2(NLP_MS) : 1;
    localparam logic [NW-1:0] LAST = NW'(NLP_MS - 1);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic          pulse;
    } nlp_s_t;

    nlp_s_t gen_d, gen_q;

    always_comb begin
        gen_d       = gen_q;
        gen_d.pulse = 1'b0;
        if (tx_busy) begin
            gen_d.cnt = '0;
        end else if (ms_tick) begin
            if (gen_q.cnt == LAST) begin
                gen_d.cnt   = '0;
                gen_d.pulse = 1'b1;
            end else begin
                gen_d.cnt = gen_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign nlp_pulse = gen_q.pulse;
endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor
    import lnk_pkg::*;
#(
    parameter int LOSS_MS     = 100,
    parameter int PASS_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_lp,
    input  logic rx_pkt,
    input  logic chk_strap,
    output logic link_good
);
    localparam int LW = (LOSS_MS > 2) ? $clog2(LOSS_MS) : 1;
    localparam int PW = (PASS_PULSES > 1) ? $clog2(PASS_PULSES + 1) : 1;
    localparam logic [LW-1:0] WIN_LAST = LW'(LOSS_MS - 1);
    localparam logic [PW-1:0] PC_LAST  = PW'(PASS_PULSES - 1);

    typedef struct packed {
        lnk_state_e    state;
        logic [LW-1:0] win;
        logic [PW-1:0] pcnt;
    } mon_s_t;

    mon_s_t mon_d, mon_q;
    logic   activity, expire;

    always_comb begin
        activity = rx_lp | rx_pkt;
        expire   = ms_tick && (mon_q.win == WIN_LAST);
        mon_d    = mon_q;
        if (!chk_strap) begin
            // bypass: held good with a fresh window
            mon_d.state = LNK_PASS;
            mon_d.win   = '0;
            mon_d.pcnt  = '0;
        end else begin
            case (mon_q.state)
                LNK_PASS: begin
                    if (activity) begin
                        mon_d.win = '0;
                    end else if (expire) begin
                        mon_d.state = LNK_FAIL;
                        mon_d.win   = '0;
                        mon_d.pcnt  = '0;
                    end else if (ms_tick) begin
                        mon_d.win = mon_q.win + 1'b1;
                    end
                end
                default: begin
                    if (rx_pkt) begin
                        mon_d.state = LNK_PASS;
                        mon_d.win   = '0;
                        mon_d.pcnt  = '0;
                    end else if (rx_lp) begin
                        mon_d.win = '0;
                        if (mon_q.pcnt == PC_LAST) begin
                            mon_d.state = LNK_PASS;
                            mon_d.pcnt  = '0;
                        end else begin
                            mon_d.pcnt = mon_q.pcnt + 1'b1;
                        end
                    end else if (expire) begin
                        mon_d.win  = '0;
                        mon_d.pcnt = '0;
                    end else if (ms_tick) begin
                        mon_d.win = mon_q.win + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.state <= LNK_FAIL;
            mon_q.win   <= '0;
            mon_q.pcnt  <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign link_good = (mon_q.state == LNK_PASS);
endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon #(
    parameter int LOSS_MS     = 100,
    parameter int NLP_MS      = 16,
    parameter int PASS_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_lp,
    input  logic rx_pkt,
    input  logic tx_busy,
    input  logic chk_strap,
    output logic link_ok_n,
    output logic tx_en,
    output logic rx_en,
    output logic nlp_out
);
    logic link_good;

    lnk_monitor #(
        .LOSS_MS    (LOSS_MS),
        .PASS_PULSES(PASS_PULSES)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .rx_lp    (rx_lp),
        .rx_pkt   (rx_pkt),
        .chk_strap(chk_strap),
        .link_good(link_good)
    );

    lnk_nlp_gen #(
        .NLP_MS(NLP_MS)
    ) u_nlp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .tx_busy  (tx_busy),
        .nlp_pulse(nlp_out)
    );

    assign link_ok_n = ~link_good;
    assign tx_en     = link_good;
    assign rx_en     = link_good;
endmodule

// File: rtl/lnk_integrity_mon_chk.sv
module lnk_integrity_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic rx_lp,
    input logic rx_pkt,
    input logic tx_busy,
    input logic chk_strap,
    input logic link_ok_n,
    input logic tx_en,
    input logic rx_en,
    input logic nlp_out
);
    // R2: a failed link leaves failure only on a line event
    assert_fail_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strap && link_ok_n && !rx_lp && !rx_pkt |=> link_ok_n);

    assert_pkt_recovers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strap && link_ok_n && rx_pkt |=> !link_ok_n);

    assert_loss_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strap && !link_ok_n && !ms_tick |=> !link_ok_n);

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strap && !link_ok_n && (rx_lp || rx_pkt) |=> !link_ok_n);

    assert_bypass_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_strap |=> !link_ok_n && tx_en && rx_en);

    assert_nlp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nlp_out |=> !nlp_out);

    assert_nlp_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nlp_out |-> $past(ms_tick));

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> !nlp_out);
endmodule

bind lnk_integrity_mon lnk_integrity_mon_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .rx_lp    (rx_lp),
    .rx_pkt   (rx_pkt),
    .tx_busy  (tx_busy),
    .chk_strap(chk_strap),
    .link_ok_n(link_ok_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .nlp_out  (nlp_out)
);

// File: tb/lnk_integrity_mon_test.sv
module lnk_integrity_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOSS  = 6;
    localparam int NLP   = 4;
    localparam int PULSE = 2;

    logic clk = 1'b0;
    logic rst_n, ms_tick, rx_lp, rx_pkt, tx_busy, chk_strap;
    logic link_ok_n, tx_en, rx_en, nlp_out;

    int n_chk = 0;
    int n_bad = 0;
    int nlp_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lnk_integrity_mon #(
        .LOSS_MS(LOSS), .NLP_MS(NLP), .PASS_PULSES(PULSE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rx_lp(rx_lp),
        .rx_pkt(rx_pkt), .tx_busy(tx_busy), .chk_strap(chk_strap),
        .link_ok_n(link_ok_n), .tx_en(tx_en), .rx_en(rx_en), .nlp_out(nlp_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // status triple packed as {link_ok_n, tx_en, rx_en}: good = 3'b011, failed = 3'b100
    function automatic int st();
        return {link_ok_n, tx_en, rx_en};
    endfunction

    task automatic cyc(input logic lp, input logic pkt, input logic tk);
        rx_lp = lp; rx_pkt = pkt; ms_tick = tk;
        @(negedge clk);
        if (nlp_out) nlp_seen++;
        rx_lp = 1'b0; rx_pkt = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1);
        check("R1 status in reset", st(), 3'b100);
        check("R1 nlp in reset", nlp_out, 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        check("R1 status after release", st(), 3'b100);
        check("R1 nlp after release", nlp_out, 0);
    endtask

    task automatic t_pulse_pass();
        cyc(1'b1, 1'b0, 1'b0);
        check("R2 one pulse short", st(), 3'b100);
        cyc(1'b1, 1'b0, 1'b0);
        check("R2 pass on pulse count", st(), 3'b011);
    endtask

    task automatic t_loss();
        ticks(LOSS - 1);
        check("R4 good before window end", st(), 3'b011);
        ticks(1);
        check("R4 failed at window end", st(), 3'b100);
    endtask

    task automatic t_pkt();
        cyc(1'b0, 1'b1, 1'b0);
        check("R3 packet recovers", st(), 3'b011);
    endtask

    task automatic t_race();
        ticks(LOSS - 1);
        cyc(1'b1, 1'b0, 1'b1);
        check("R5 pulse beats final tick", st(), 3'b011);
        ticks(LOSS - 1);
        check("R5 window restarted", st(), 3'b011);
        ticks(1);
        check("R5 fails after fresh window", st(), 3'b100);
    endtask

    task automatic t_consec();
        cyc(1'b1, 1'b0, 1'b0);
        ticks(LOSS);
        check("R6 still failed", st(), 3'b100);
        cyc(1'b1, 1'b0, 1'b0);
        check("R6 stale pulse discarded", st(), 3'b100);
        cyc(1'b1, 1'b0, 1'b0);
        check("R6 fresh pair passes", st(), 3'b011);
    endtask

    task automatic t_strap();
        ticks(LOSS);
        check("R7 failed before strap", st(), 3'b100);
        chk_strap = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        check("R7 bypass forces good", st(), 3'b011);
        ticks(LOSS + 4);
        check("R7 bypass ignores silence", st(), 3'b011);
        chk_strap = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        check("R7 good after strap release", st(), 3'b011);
        ticks(LOSS - 1);
        check("R7 fresh window", st(), 3'b011);
        ticks(1);
        check("R7 check active again", st(), 3'b100);
    endtask

    task automatic t_nlp();
        chk_strap = 1'b0;
        tx_busy   = 1'b0;
        ticks(NLP - 1);
        check("R8 no pulse early", nlp_out, 0);
        ticks(1);
        check("R8 pulse at period", nlp_out, 1);
        cyc(1'b0, 1'b0, 1'b0);
        check("R8 pulse one cycle", nlp_out, 0);
        nlp_seen = 0;
        ticks(2 * NLP);
        check("R8 two periods two pulses", nlp_seen, 2);
        chk_strap = 1'b1;
    endtask

    task automatic t_busy();
        ticks(NLP - 1);
        tx_busy = 1'b1;
        nlp_seen = 0;
        ticks(1);
        check("R9 busy beats period tick", nlp_out, 0);
        ticks(3 * NLP);
        check("R9 quiet while busy", nlp_seen, 0);
        tx_busy = 1'b0;
        ticks(NLP - 1);
        check("R9 timer restarted", nlp_out, 0);
        ticks(1);
        check("R9 first pulse after busy", nlp_out, 1);
    endtask

    initial begin
        rst_n = 1'b0; ms_tick = 1'b0; rx_lp = 1'b0; rx_pkt = 1'b0;
        tx_busy = 1'b1; chk_strap = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        t_reset();
        t_pulse_pass();
        t_loss();
        t_pkt();
        t_race();
        t_consec();
        t_strap();
        t_nlp();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule